// File: doc/BRIEF.md
# Multi-Output Video Timing Generator

This block produces the raster timing for a display pipeline. It runs a sample counter across each line and a line counter across each field, both from its own clock, and drives four sync ports. Every port has its own horizontal sync window and its own vertical sync edges. Because each vertical edge is given as a line number plus a sample offset, a port that feeds a path with a longer or shorter pipeline can have its vertical pulse start late, or start in the last line of the previous field. Alongside the sync ports the block drives an active-video flag for a rectangular window and raises top-field and bottom-field interrupt events.

Software sets up the block through a word-addressed write port and a combinational read port. The mode register resets to 1, which holds the block stopped. Writing 0 starts free-running timing. A separate restart register puts the counters back to the first sample of the first line. The field length is programmed in half-lines. An even count gives progressive video, where every field is a top field. An odd count makes fields alternate between top and bottom, and each port and the window then use their bottom-field settings during bottom fields.

The timebase is a two-state machine. HALT holds the counters at line 1, sample 0 and forces every output low. RUN advances the counters. The START transition from HALT to RUN is taken when the mode register reads 0. The STOP transition from RUN to HALT is taken when it reads any other value. Each transition takes effect one clock after the mode write.

Top module: `video_timing_core`

## Requirements
- R1: The mode register (address 0x00) resets to 1. While it is nonzero the block is in HALT from the following clock on: hsync, vsync and active outputs are low and no interrupt event is raised. Writing 0 enters RUN at the following clock, with the counters at line 1, sample 0.
- R2: In RUN the sample counter steps 0 to CPL-1 and the line counter steps 1 to HLF/2 (rounded down), then both wrap. CPL is address 0x01 bits 15:0 and HLF is address 0x02 bits 15:0.
- R3: Each of the four ports has an hsync register at address 0x10+8*p with stop in bits 31:16 and start in bits 15:0. The port's hsync is high while start <= sample < stop. When stop < start the pulse wraps past the end of the line (sample >= start or sample < stop). The ports are independent.
- R4: Each port has vertical line registers (top at 0x11+8*p, bottom at 0x12+8*p) and vertical offset registers (top at 0x13+8*p, bottom at 0x14+8*p), each packed as fall in bits 31:16 and rise in bits 15:0. Vsync goes high on the clock after the counters show (rise line, rise offset) and goes low on the clock after they show (fall line, fall offset). A rise match wins over a fall match.
- R5: The active output is high when the line and sample lie inside the inclusive window of the current field. Window registers: top start 0x04, top stop 0x05, bottom start 0x06, bottom stop 0x07, each packed as line in bits 31:16 and pixel in bits 15:0.
- R6: With an even HLF every field is a top field. With an odd HLF, fields alternate top, bottom, top, starting from top after a restart or a START. Bottom fields use the bottom vertical registers and the bottom window.
- R7: Interrupt status (read at 0x08) bit 1 sets on the clock after the counters show line 1, sample 0 in RUN during a top field. Bit 0 does the same for a bottom field.
- R8: Writing to address 0x09 clears the status bits that are 1 in the written data. Other bits stay set. A set event in the same cycle wins over the clear.
- R9: Writing to 0x0B sets mask bits and writing to 0x0A clears them. Both addresses read back the mask. irq_o is high exactly when some status bit and its mask bit are both 1.
- R10: Writing 1 in bit 0 to address 0x03 puts the counters at line 1, sample 0, top field and clears every vsync on that clock. Writing 0 there has no effect.
- R11: The mode, CPL, HLF, window and port registers read back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Word address for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| hsync_o | output | 4 | Horizontal sync, one bit per port |
| vsync_o | output | 4 | Vertical sync, one bit per port |
| active_o | output | 1 | Active-video window flag |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The hardest behaviour to reach from the ports is the bottom field. It exists only when the half-line count is odd, and it is visible only through the bottom-field vertical and window settings. The stimulus halts the block, loads an odd count together with bottom-field settings that differ from the top ones, and then restarts. A model is then stepped through a top, a bottom and another top field, checking every output on every cycle. A vsync rise placed in the last line before line 1 shows the edge-by-offset behaviour. The interrupt scenario sets clears at known distances from the field start, so that sticky bits, partial clears and masking are each seen on their own.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
    localparam int DATA_W      = 32;
    localparam int HALF_W      = DATA_W / 2;
    localparam int ADDR_W      = 6;
    localparam int PORT_REGS   = 5;
    localparam int PORT_STRIDE = 8;

    localparam logic [ADDR_W-1:0] A_MODE      = 6'h00;
    localparam logic [ADDR_W-1:0] A_CPL       = 6'h01;
    localparam logic [ADDR_W-1:0] A_HLF       = 6'h02;
    localparam logic [ADDR_W-1:0] A_RESTART   = 6'h03;
    localparam logic [ADDR_W-1:0] A_WIN_TS    = 6'h04;
    localparam logic [ADDR_W-1:0] A_WIN_TE    = 6'h05;
    localparam logic [ADDR_W-1:0] A_WIN_BS    = 6'h06;
    localparam logic [ADDR_W-1:0] A_WIN_BE    = 6'h07;
    localparam logic [ADDR_W-1:0] A_STAT      = 6'h08;
    localparam logic [ADDR_W-1:0] A_STAT_CLR  = 6'h09;
    localparam logic [ADDR_W-1:0] A_MASK_CLR  = 6'h0A;
    localparam logic [ADDR_W-1:0] A_MASK_SET  = 6'h0B;
    localparam logic [ADDR_W-1:0] A_PORT_BASE = 6'h10;

    localparam int IRQ_BOT = 0;
    localparam int IRQ_TOP = 1;

    typedef enum logic {
        TB_HALT,
        TB_RUN
    } tb_state_e;

    // upper half: later / falling edge, lower half: earlier / rising edge
    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } pair_t;

    typedef struct packed {
        pair_t hs;
        pair_t vl_top;
        pair_t vl_bot;
        pair_t vo_top;
        pair_t vo_bot;
    } port_cfg_t;

    // each pair: hi = line, lo = pixel
    typedef struct packed {
        pair_t top_start;
        pair_t top_stop;
        pair_t bot_start;
        pair_t bot_stop;
    } win_cfg_t;
endpackage

// File: rtl/vtc_regs.sv
module vtc_regs
    import vtc_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              top_evt,
    input  logic              bot_evt,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] mode,
    output logic [HALF_W-1:0] cpl,
    output logic [HALF_W-1:0] hlf,
    output logic              restart,
    output win_cfg_t          win,
    output port_cfg_t         port_cfg [NPORT],
    output logic [1:0]        status,
    output logic [1:0]        mask
);
    logic [DATA_W-1:0] port_q [NPORT][PORT_REGS];
    logic [DATA_W-1:0] win_q  [4];
    logic [1:0]        stat_clr, mask_clr, mask_set;

    function automatic logic [ADDR_W-1:0] port_addr(input int p, input int k);
        return A_PORT_BASE + ADDR_W'(p * PORT_STRIDE + k);
    endfunction

    assign restart  = wr_en && (addr == A_RESTART) && wdata[0];
    assign stat_clr = (wr_en && addr == A_STAT_CLR) ? wdata[1:0] : 2'b00;
    assign mask_clr = (wr_en && addr == A_MASK_CLR) ? wdata[1:0] : 2'b00;
    assign mask_set = (wr_en && addr == A_MASK_SET) ? wdata[1:0] : 2'b00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= DATA_W'(1);
            cpl  <= '0;
            hlf  <= '0;
            for (int w = 0; w < 4; w++) win_q[w] <= '0;
            for (int p = 0; p < NPORT; p++)
                for (int k = 0; k < PORT_REGS; k++) port_q[p][k] <= '0;
        end else if (wr_en) begin
            if (addr == A_MODE) mode <= wdata;
            if (addr == A_CPL)  cpl  <= wdata[HALF_W-1:0];
            if (addr == A_HLF)  hlf  <= wdata[HALF_W-1:0];
            for (int w = 0; w < 4; w++)
                if (addr == A_WIN_TS + ADDR_W'(w)) win_q[w] <= wdata;
            for (int p = 0; p < NPORT; p++)
                for (int k = 0; k < PORT_REGS; k++)
                    if (addr == port_addr(p, k)) port_q[p][k] <= wdata;
        end
    end

    // event set wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= 2'b00;
            mask   <= 2'b00;
        end else begin
            status <= (status & ~stat_clr) | {top_evt, bot_evt};
            mask   <= (mask & ~mask_clr) | mask_set;
        end
    end

    assign win = {win_q[0], win_q[1], win_q[2], win_q[3]};

    for (genvar p = 0; p < NPORT; p++) begin : g_cfg
        assign port_cfg[p] = {port_q[p][0], port_q[p][1], port_q[p][2],
                              port_q[p][3], port_q[p][4]};
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_MODE:     rdata = mode;
            A_CPL:      rdata = DATA_W'(cpl);
            A_HLF:      rdata = DATA_W'(hlf);
            A_WIN_TS:   rdata = win_q[0];
            A_WIN_TE:   rdata = win_q[1];
            A_WIN_BS:   rdata = win_q[2];
            A_WIN_BE:   rdata = win_q[3];
            A_STAT:     rdata = DATA_W'(status);
            A_MASK_CLR: rdata = DATA_W'(mask);
            A_MASK_SET: rdata = DATA_W'(mask);
            default:    rdata = '0;
        endcase
        for (int p = 0; p < NPORT; p++)
            for (int k = 0; k < PORT_REGS; k++)
                if (addr == port_addr(p, k)) rdata = port_q[p][k];
    end
endmodule

// File: rtl/vtc_timebase.sv
module vtc_timebase
    import vtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] mode,
    input  logic [HALF_W-1:0] cpl,
    input  logic [HALF_W-1:0] hlf,
    input  logic              restart,
    output logic              run,
    output logic [HALF_W-1:0] line,
    output logic [HALF_W-1:0] sample,
    output logic              top,
    output logic              top_evt,
    output logic              bot_evt
);
    tb_state_e state_q, state_d;
    logic      end_of_line, end_of_field;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TB_HALT;
        else        state_q <= state_d;
    end

    // START / STOP transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TB_HALT: if (mode == '0) state_d = TB_RUN;
            TB_RUN:  if (mode != '0) state_d = TB_HALT;
            default: state_d = TB_HALT;
        endcase
    end

    // outputs of the machine
    always_comb begin
        run     = (state_q == TB_RUN);
        top_evt = run && line == HALF_W'(1) && sample == '0 && top;
        bot_evt = run && line == HALF_W'(1) && sample == '0 && !top;
    end

    assign end_of_line  = ({1'b0, sample} + (HALF_W+1)'(1)) >= {1'b0, cpl};
    assign end_of_field = line >= (hlf >> 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample <= '0;
            line   <= HALF_W'(1);
            top    <= 1'b1;
        end else if (state_q != TB_RUN || restart) begin
            sample <= '0;
            line   <= HALF_W'(1);
            top    <= 1'b1;
        end else if (end_of_line) begin
            sample <= '0;
            if (end_of_field) begin
                line <= HALF_W'(1);
                top  <= hlf[0] ? !top : 1'b1;
            end else begin
                line <= line + HALF_W'(1);
            end
        end else begin
            sample <= sample + HALF_W'(1);
        end
    end
endmodule

// File: rtl/vtc_sync_port.sv
module vtc_sync_port
    import vtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [HALF_W-1:0] line,
    input  logic [HALF_W-1:0] sample,
    input  logic              top,
    input  port_cfg_t         cfg,
    output logic              hsync,
    output logic              vsync
);
    pair_t vl, vo;
    logic  hs_in, rise_hit, fall_hit, vs_q;

    always_comb begin
        if (cfg.hs.lo <= cfg.hs.hi) hs_in = (sample >= cfg.hs.lo) && (sample < cfg.hs.hi);
        else                        hs_in = (sample >= cfg.hs.lo) || (sample < cfg.hs.hi);
    end

    assign vl       = top ? cfg.vl_top : cfg.vl_bot;
    assign vo       = top ? cfg.vo_top : cfg.vo_bot;
    assign rise_hit = (line == vl.lo) && (sample == vo.lo);
    assign fall_hit = (line == vl.hi) && (sample == vo.hi);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               vs_q <= 1'b0;
        else if (!run || restart) vs_q <= 1'b0;
        else if (rise_hit)        vs_q <= 1'b1;
        else if (fall_hit)        vs_q <= 1'b0;
    end

    assign hsync = run && hs_in;
    assign vsync = run && vs_q;
endmodule

// File: rtl/vtc_window.sv
module vtc_window
    import vtc_pkg::*;
(
    input  logic              run,
    input  logic [HALF_W-1:0] line,
    input  logic [HALF_W-1:0] sample,
    input  logic              top,
    input  win_cfg_t          win,
    output logic              active
);
    pair_t w_start, w_stop;

    assign w_start = top ? win.top_start : win.bot_start;
    assign w_stop  = top ? win.top_stop  : win.bot_stop;
    assign active  = run && (line >= w_start.hi) && (line <= w_stop.hi)
                         && (sample >= w_start.lo) && (sample <= w_stop.lo);
endmodule

// File: rtl/video_timing_core.sv
module video_timing_core
    import vtc_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NPORT-1:0]  hsync_o,
    output logic [NPORT-1:0]  vsync_o,
    output logic              active_o,
    output logic              irq_o
);
    logic [DATA_W-1:0] mode_w;
    logic [HALF_W-1:0] cpl_w, hlf_w, tb_line, tb_sample;
    logic              restart_w, tb_run, tb_top, top_evt, bot_evt;
    logic [1:0]        irq_status, irq_mask;
    win_cfg_t          win_w;
    port_cfg_t         port_cfg [NPORT];

    vtc_regs #(.NPORT(NPORT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .top_evt(top_evt), .bot_evt(bot_evt), .rdata(rdata), .mode(mode_w),
        .cpl(cpl_w), .hlf(hlf_w), .restart(restart_w), .win(win_w),
        .port_cfg(port_cfg), .status(irq_status), .mask(irq_mask)
    );

    vtc_timebase u_timebase (
        .clk(clk), .rst_n(rst_n), .mode(mode_w), .cpl(cpl_w), .hlf(hlf_w),
        .restart(restart_w), .run(tb_run), .line(tb_line), .sample(tb_sample),
        .top(tb_top), .top_evt(top_evt), .bot_evt(bot_evt)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        vtc_sync_port u_port (
            .clk(clk), .rst_n(rst_n), .run(tb_run), .restart(restart_w),
            .line(tb_line), .sample(tb_sample), .top(tb_top), .cfg(port_cfg[p]),
            .hsync(hsync_o[p]), .vsync(vsync_o[p])
        );
    end

    vtc_window u_window (
        .run(tb_run), .line(tb_line), .sample(tb_sample), .top(tb_top),
        .win(win_w), .active(active_o)
    );

    assign irq_o = |(irq_status & irq_mask);
endmodule

// File: rtl/vtc_checker.sv
module vtc_checker
    import vtc_pkg::*;
#(
    parameter int NPORT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              run,
    input logic [HALF_W-1:0] line,
    input logic [HALF_W-1:0] sample,
    input logic              top,
    input logic [HALF_W-1:0] cpl,
    input logic [1:0]        status,
    input logic [1:0]        mask,
    input logic [NPORT-1:0]  hsync_o,
    input logic [NPORT-1:0]  vsync_o,
    input logic              active_o,
    input logic              irq_o
);
    logic restart_wr, top_clr_wr;
    assign restart_wr = wr_en && addr == A_RESTART && wdata[0];
    assign top_clr_wr = wr_en && addr == A_STAT_CLR && wdata[IRQ_TOP];

    assert_halt_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (hsync_o == '0 && vsync_o == '0 && !active_o));

    assert_line_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line != '0);

    assert_sample_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cpl != '0 && sample == cpl - HALF_W'(1) && !restart_wr) |=> sample == '0);

    assert_top_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && line == HALF_W'(1) && sample == '0 && top) |=> status[IRQ_TOP]);

    assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[IRQ_TOP] && !top_clr_wr) |=> status[IRQ_TOP]);

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 2'b00) |-> !irq_o);

    assert_restart_home_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart_wr |=> (line == HALF_W'(1) && sample == '0 && top && vsync_o == '0));
endmodule

bind video_timing_core vtc_checker #(.NPORT(NPORT)) u_vtc_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .run(tb_run), .line(tb_line), .sample(tb_sample), .top(tb_top), .cpl(cpl_w),
    .status(irq_status), .mask(irq_mask), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .active_o(active_o), .irq_o(irq_o)
);

// File: tb/tb_video_timing_core.sv
module tb_video_timing_core;
    import vtc_pkg::*;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [5:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] hsync_o, vsync_o;
    logic          active_o, irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // bench model
    int          m_cpl, m_lines, m_line, m_samp;
    bit          m_odd, m_top;
    bit [NP-1:0] m_vs;
    logic [31:0] m_hs[NP], m_vlt[NP], m_vlb[NP], m_vot[NP], m_vob[NP];
    logic [31:0] m_win[4];

    video_timing_core #(.NPORT(NP)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .active_o(active_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic set_port(input int p, input logic [31:0] hs, vlt, vlb, vot, vob);
        wr(6'(16 + 8*p + 0), hs);  m_hs[p]  = hs;
        wr(6'(16 + 8*p + 1), vlt); m_vlt[p] = vlt;
        wr(6'(16 + 8*p + 2), vlb); m_vlb[p] = vlb;
        wr(6'(16 + 8*p + 3), vot); m_vot[p] = vot;
        wr(6'(16 + 8*p + 4), vob); m_vob[p] = vob;
    endtask

    task automatic set_win(input int w, input logic [31:0] v);
        wr(A_WIN_TS + 6'(w), v);
        m_win[w] = v;
    endtask

    function automatic bit hs_fn(input int s, input logic [31:0] r);
        int st, sp;
        st = int'(r[15:0]);
        sp = int'(r[31:16]);
        if (st <= sp) return (s >= st) && (s < sp);
        return (s >= st) || (s < sp);
    endfunction

    task automatic model_restart();
        m_line = 1; m_samp = 0; m_top = 1'b1; m_vs = '0;
    endtask

    task automatic model_step();
        for (int p = 0; p < NP; p++) begin
            logic [31:0] vl, vo;
            vl = m_top ? m_vlt[p] : m_vlb[p];
            vo = m_top ? m_vot[p] : m_vob[p];
            if (m_line == int'(vl[15:0]) && m_samp == int'(vo[15:0]))        m_vs[p] = 1'b1;
            else if (m_line == int'(vl[31:16]) && m_samp == int'(vo[31:16])) m_vs[p] = 1'b0;
        end
        if (m_samp >= m_cpl - 1) begin
            m_samp = 0;
            if (m_line >= m_lines) begin
                m_line = 1;
                m_top  = m_odd ? !m_top : 1'b1;
            end else begin
                m_line++;
            end
        end else begin
            m_samp++;
        end
    endtask

    task automatic check_now(input string tag);
        logic [NP-1:0] eh;
        logic [31:0]   ws, we;
        bit            ea;
        for (int p = 0; p < NP; p++) eh[p] = hs_fn(m_samp, m_hs[p]);
        ws = m_top ? m_win[0] : m_win[2];
        we = m_top ? m_win[1] : m_win[3];
        ea = m_line >= int'(ws[31:16]) && m_line <= int'(we[31:16]) &&
             m_samp >= int'(ws[15:0])  && m_samp <= int'(we[15:0]);
        chk(hsync_o == eh, {tag, " R3"}, $sformatf("hsync line %0d sample %0d", m_line, m_samp),
            32'(hsync_o), 32'(eh));
        chk(vsync_o == m_vs, {tag, " R4"}, $sformatf("vsync line %0d sample %0d", m_line, m_samp),
            32'(vsync_o), 32'(m_vs));
        chk(active_o == ea, {tag, " R5"}, $sformatf("active line %0d sample %0d", m_line, m_samp),
            32'(active_o), 32'(ea));
    endtask

    task automatic check_span(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            check_now(tag);
            @(negedge clk);
            model_step();
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_MODE, v); chk(v == 32'd1, "R1", "mode after reset", v, 32'd1);
        rd(A_CPL, v);  chk(v == 32'd0, "R11", "cpl after reset", v, 32'd0);
        rd(A_STAT, v); chk(v == 32'd0, "R7", "status after reset", v, 32'd0);
        chk(hsync_o == '0 && vsync_o == '0 && !active_o, "R1", "outputs after reset",
            {hsync_o, vsync_o, 23'd0, active_o}, 32'd0);
        chk(!irq_o, "R9", "irq after reset", 32'(irq_o), 32'd0);
    endtask

    task automatic t_config();
        logic [31:0] v;
        m_cpl = 10; m_lines = 4; m_odd = 1'b0;
        wr(A_CPL, 32'd10);
        wr(A_HLF, 32'd8);
        // hsync {stop,start}, vline {fall,rise}, voffset {fall,rise}
        set_port(0, {16'd5, 16'd2}, {16'd2, 16'd1}, {16'd3, 16'd2}, {16'd3, 16'd3}, {16'd6, 16'd0});
        set_port(1, {16'd3, 16'd8}, {16'd3, 16'd2}, {16'd3, 16'd2}, {16'd0, 16'd9}, {16'd0, 16'd9});
        set_port(2, {16'd0, 16'd0}, {16'd1, 16'd4}, {16'd1, 16'd4}, {16'd4, 16'd7}, {16'd4, 16'd7});
        set_port(3, {16'd9, 16'd6}, {16'd4, 16'd1}, {16'd4, 16'd1}, {16'd5, 16'd5}, {16'd5, 16'd5});
        set_win(0, {16'd2, 16'd3});
        set_win(1, {16'd3, 16'd7});
        set_win(2, {16'd1, 16'd0});
        set_win(3, {16'd4, 16'd1});
        rd(A_CPL, v);   chk(v == 32'd10, "R11", "cpl readback", v, 32'd10);
        rd(A_HLF, v);   chk(v == 32'd8, "R11", "hlf readback", v, 32'd8);
        rd(6'h24, v);   chk(v == m_vob[2], "R11", "port2 bottom offsets readback", v, m_vob[2]);
        rd(A_WIN_BE, v); chk(v == m_win[3], "R11", "bottom stop readback", v, m_win[3]);
        chk(hsync_o == '0 && !active_o, "R1", "outputs while halted",
            {hsync_o, 27'd0, active_o}, 32'd0);
    endtask

    task automatic t_frames();
        wr(A_MODE, 32'd0);
        wr(A_RESTART, 32'd1);
        model_restart();
        check_span(100, "R2");
        wr(A_RESTART, 32'd0);
        model_step();
        check_span(25, "R10 zero-write");
        wr(A_RESTART, 32'd1);
        model_restart();
        check_span(12, "R10 restart");
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(A_MODE, 32'd1);
        wr(A_STAT_CLR, 32'd3);
        wr(A_STAT_CLR, 32'd3);
        rd(A_STAT, v); chk(v == 32'd0, "R8", "status cleared", v, 32'd0);
        wr(A_MASK_CLR, 32'd3);
        wr(A_MASK_SET, 32'd2);
        rd(A_MASK_SET, v); chk(v == 32'd2, "R9", "mask readback", v, 32'd2);
        chk(!irq_o, "R9", "irq with empty status", 32'(irq_o), 32'd0);
        wr(A_MODE, 32'd0);
        rd(A_STAT, v); chk(v == 32'd0, "R7", "status before first run cycle", v, 32'd0);
        @(negedge clk);
        @(negedge clk);
        rd(A_STAT, v); chk(v == 32'd2, "R7", "top event flagged", v, 32'd2);
        chk(irq_o, "R9", "irq with enabled top bit", 32'(irq_o), 32'd1);
        wr(A_MASK_CLR, 32'd2);
        chk(!irq_o, "R9", "irq after mask clear", 32'(irq_o), 32'd0);
        wr(A_MASK_SET, 32'd1);
        chk(!irq_o, "R9", "irq with only bottom enabled", 32'(irq_o), 32'd0);
        wr(A_STAT_CLR, 32'd1);
        rd(A_STAT, v); chk(v == 32'd2, "R8", "partial clear keeps top", v, 32'd2);
        wr(A_STAT_CLR, 32'd2);
        rd(A_STAT, v); chk(v == 32'd0, "R8", "top bit cleared", v, 32'd0);
        wr(A_MASK_CLR, 32'd3);
    endtask

    task automatic t_odd();
        logic [31:0] v;
        wr(A_MODE, 32'd1);
        wr(A_HLF, 32'd9);
        set_port(0, m_hs[0], m_vlt[0], {16'd3, 16'd2}, m_vot[0], {16'd6, 16'd0});
        set_win(2, {16'd3, 16'd1});
        set_win(3, {16'd4, 16'd8});
        wr(A_STAT_CLR, 32'd3);
        m_odd = 1'b1;
        wr(A_MODE, 32'd0);
        wr(A_RESTART, 32'd1);
        model_restart();
        check_span(85, "R6");
        rd(A_STAT, v); chk(v == 32'd3, "R6", "top and bottom events seen", v, 32'd3);
    endtask

    task automatic t_halt();
        logic [31:0] v;
        wr(A_MODE, 32'd2);
        @(negedge clk);
        wr(A_STAT_CLR, 32'd3);
        for (int i = 0; i < 45; i++) begin
            if (i % 15 == 0)
                chk(hsync_o == '0 && vsync_o == '0 && !active_o, "R1", "outputs in halt",
                    {hsync_o, vsync_o, 23'd0, active_o}, 32'd0);
            @(negedge clk);
        end
        rd(A_STAT, v); chk(v == 32'd0, "R1", "no events in halt", v, 32'd0);
        rd(A_MODE, v); chk(v == 32'd2, "R11", "mode readback", v, 32'd2);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_frames();
        t_irq();
        t_odd();
        t_halt();
        done = 1'b1;
        report();
        $finish;
    end
endmodule